// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer for 9-bit words whose write side and read side run on independent free-running clocks. Write and read pointers pass between the two domains as Gray code through two-flop synchronisers. Four active-low status outputs are provided. Empty and almost-empty are produced on the read clock. Full and almost-full are produced on the write clock. Each of these flags asserts on the clock edge of the local access that causes it. A flag that is released by an access from the far side clears a few cycles later, because the far pointer must first cross the synchroniser.

The input `wen2_ld` serves two purposes. Its level while reset is held low selects the operating mode. A high level gives a plain second write qualifier. A low level gives programmable-flag mode, and in that mode the pin is a load strobe for the two threshold registers. The read side has two active-low read enables and an output enable. When the output enable is deasserted, the output data is released to high impedance.

Top module: `dcfifo_pflag`

## Requirements
- R1: While `rst_n` is low, both pointers return to the first location, `empty_n` and `aempty_n` are 0, `full_n` and `afull_n` are 1, the output register is cleared to 0, and the thresholds return to 7.
- R2: The level of `wen2_ld` at the write-clock edges during reset selects the mode: 1 gives two-enable mode, 0 gives programmable-flag mode. The mode then holds until the next reset.
- R3: A word is written at a `wclk` rising edge only when `wen1_n` is 0 and `wen2_ld` is 1. This is true in both modes. In two-enable mode, `wen2_ld` at 0 has no effect.
- R4: A word is read into the output register at an `rclk` rising edge only when `ren1_n` and `ren2_n` are both 0. If only one of them is low, the pointer and `rdata` do not change.
- R5: A write attempted while `full_n` is 0 is discarded. A read attempted while `empty_n` is 0 is discarded, and `rdata` keeps the last word read.
- R6: Words come out in the order they were written, with the two clocks unrelated. `empty_n` is 0 whenever the buffer holds no word. `full_n` is 0 whenever it holds DEPTH words. Each flag releases within a few cycles after the far side makes room or supplies data.
- R7: With default thresholds of 7, `aempty_n` is 0 exactly when 7 or fewer words are stored. `afull_n` is 0 exactly when 7 or fewer free locations remain.
- R8: When `oe_n` is 1, every bit of `rdata` is high impedance. When `oe_n` is 0, `rdata` shows the output register.
- R9: In programmable-flag mode, each `wclk` edge with `wen1_n`=0 and `wen2_ld`=0 loads `wdata[AW-1:0]` into a threshold register and writes no data. Successive loads go to the almost-empty threshold first, then the almost-full threshold, and the sequence then wraps back to the first. The loaded values replace the 7 used in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wdata | input | 9 | Write data, or a threshold value during a load |
| wen1_n | input | 1 | Active-low write enable |
| wen2_ld | input | 1 | Mode select at reset; after reset, a write qualifier or a threshold load strobe |
| ren1_n | input | 1 | Active-low read enable, first |
| ren2_n | input | 1 | Active-low read enable, second |
| oe_n | input | 1 | Active-low output enable |
| rdata | output | 9 | Output register, or high impedance |
| empty_n | output | 1 | Active-low empty flag, read domain |
| aempty_n | output | 1 | Active-low almost-empty flag, read domain |
| full_n | output | 1 | Active-low full flag, write domain |
| afull_n | output | 1 | Active-low almost-full flag, write domain |

## Verification
A read puts its word on `rdata` at the same `rclk` edge. The bench compares that word against its queue model at the following falling edge. `empty_n` and `full_n` assert at the edge of the local access, so the bench checks them at every falling edge: whenever the model is empty or full, the matching flag must already be low. A release that depends on the far pointer is due three far-side edges after the access, and the almost flags follow the same timing. For these results, the bench waits eight write-clock cycles with no activity before it compares the flag levels with the thresholds.

// File: rtl/dcfifo_pflag.sv
`timescale 1ns/1ps
module dcfifo_pflag #(
  parameter int DW     = 9,
  parameter int AW     = 4,
  parameter int DEF_AE = 7,
  parameter int DEF_AF = 7
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic [DW-1:0] wdata,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic          oe_n,
  output logic [DW-1:0] rdata,
  output logic          empty_n,
  output logic          aempty_n,
  output logic          full_n,
  output logic          afull_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] q_r;
  logic          pf_mode, ld_sel;
  logic [AW-1:0] ae_off, af_off;

  logic [PW-1:0] wbin, wgray, rq1, rq2;
  logic [PW-1:0] rbin, rgray, wq1, wq2;

  // write domain
  logic          wr_go, ld_go;
  logic [PW-1:0] wbin_nx, wgray_nx, wlevel_nx;

  assign wr_go     = !wen1_n && wen2_ld && full_n;
  assign ld_go     = pf_mode && !wen1_n && !wen2_ld;
  assign wbin_nx   = wbin + PW'(wr_go);
  assign wgray_nx  = (wbin_nx >> 1) ^ wbin_nx;
  assign wlevel_nx = wbin_nx - g2b(rq2);

  always_ff @(posedge wclk)
    if (!rst_n) pf_mode <= !wen2_ld;

  always_ff @(posedge wclk)
    if (wr_go) mem[wbin[AW-1:0]] <= wdata;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      rq1     <= '0;
      rq2     <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
      ae_off  <= AW'(DEF_AE);
      af_off  <= AW'(DEF_AF);
      ld_sel  <= 1'b0;
    end else begin
      rq1     <= rgray;
      rq2     <= rq1;
      wbin    <= wbin_nx;
      wgray   <= wgray_nx;
      full_n  <= !(wgray_nx == {~rq2[AW:AW-1], rq2[AW-2:0]});
      afull_n <= !(wlevel_nx >= (PW'(DEPTH) - {1'b0, af_off}));
      if (ld_go) begin
        if (!ld_sel) ae_off <= wdata[AW-1:0];
        else         af_off <= wdata[AW-1:0];
        ld_sel <= !ld_sel;
      end
    end
  end

  // read domain
  logic          rd_go;
  logic [PW-1:0] rbin_nx, rgray_nx, rlevel_nx;

  assign rd_go     = !ren1_n && !ren2_n && empty_n;
  assign rbin_nx   = rbin + PW'(rd_go);
  assign rgray_nx  = (rbin_nx >> 1) ^ rbin_nx;
  assign rlevel_nx = g2b(wq2) - rbin_nx;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      wq1      <= '0;
      wq2      <= '0;
      q_r      <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      wq1      <= wgray;
      wq2      <= wq1;
      rbin     <= rbin_nx;
      rgray    <= rgray_nx;
      empty_n  <= !(rgray_nx == wq2);
      aempty_n <= !(rlevel_nx <= {1'b0, ae_off});
      if (rd_go) q_r <= mem[rbin[AW-1:0]];
    end
  end

  assign rdata = oe_n ? {DW{1'bz}} : q_r;

  assert_write_needs_qual_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    (wen1_n || !wen2_ld) |=> $stable(wbin));
  assert_no_write_when_full_R5: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(wbin));
  assert_read_needs_both_R4: assert property (@(posedge rclk) disable iff (!rst_n)
    (ren1_n || ren2_n) |=> $stable(rbin) && $stable(q_r));
  assert_no_read_when_empty_R5: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(rbin) && $stable(q_r));
  assert_full_implies_afull_R7: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> !afull_n);
  assert_empty_implies_aempty_R7: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);
endmodule

// File: tb/tb_dcfifo_pflag.sv
`timescale 1ns/1ps
module tb_dcfifo_pflag;
  localparam int DEPTH = 16;

  logic       wclk = 0, rclk = 0, rst_n = 0;
  logic [8:0] wdata = '0;
  logic       wen1_n = 1, wen2_ld = 1, ren1_n = 1, ren2_n = 1, oe_n = 0;
  wire  [8:0] rdata;
  logic       empty_n, aempty_n, full_n, afull_n;

  for (genvar b = 0; b < 9; b++) begin : g_pu
    pullup (rdata[b]);
  end

  dcfifo_pflag dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wdata(wdata),
    .wen1_n(wen1_n), .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n),
    .oe_n(oe_n), .rdata(rdata), .empty_n(empty_n), .aempty_n(aempty_n),
    .full_n(full_n), .afull_n(afull_n)
  );

  always #10   wclk = ~wclk;
  always #6.5  rclk = ~rclk;

  int checks = 0, errors = 0;
  logic [8:0] mq[$];
  logic [8:0] exp_rd;
  bit         rd_pend = 0;
  bit         done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge wclk)
    if (rst_n && !wen1_n && wen2_ld && full_n) mq.push_back(wdata);

  always @(posedge rclk)
    if (rst_n && !ren1_n && !ren2_n && empty_n) begin
      if (mq.size() == 0) check(0, "R6 read while model empty", 1, 0);
      else begin
        exp_rd  = mq.pop_front();
        rd_pend = 1;
      end
    end

  always @(negedge rclk) begin
    if (rd_pend) begin
      check(rdata == exp_rd, "R6 read data order", rdata, exp_rd);
      rd_pend = 0;
    end
    if (rst_n && mq.size() == 0) check(empty_n == 0, "R6 empty not late", empty_n, 0);
  end

  always @(negedge wclk)
    if (rst_n && mq.size() == DEPTH) check(full_n == 0, "R6 full not late", full_n, 0);

  task automatic settle();
    repeat (8) @(posedge wclk);
    @(negedge wclk);
  endtask

  task automatic do_reset(input logic mode);
    @(negedge wclk);
    rst_n = 0; wen2_ld = mode; wen1_n = 1; ren1_n = 1; ren2_n = 1;
    mq.delete();
    repeat (4) @(negedge wclk);
    check(empty_n == 0 && aempty_n == 0, "R1 empty flags in reset", {empty_n, aempty_n}, 0);
    check(full_n == 1 && afull_n == 1, "R1 full flags in reset", {full_n, afull_n}, 3);
    check(rdata == 0, "R1 output register cleared", rdata, 0);
    rst_n = 1;
    wen2_ld = 1;
    settle();
  endtask

  task automatic wr_burst(input int n, input logic [8:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      while (!full_n) begin
        wen1_n = 1;
        @(negedge wclk);
      end
      wdata = base + 9'(i); wen1_n = 0; wen2_ld = 1;
    end
    @(negedge wclk);
    wen1_n = 1;
  endtask

  task automatic rd_burst(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rclk);
      while (!empty_n) begin
        ren1_n = 1; ren2_n = 1;
        @(negedge rclk);
      end
      ren1_n = 0; ren2_n = 0;
    end
    @(negedge rclk);
    ren1_n = 1; ren2_n = 1;
  endtask

  initial begin
    #(20 * 150000);
    check(0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // two-enable mode
    do_reset(1'b1);
    oe_n = 1; #1;
    check(rdata == 9'h1FF, "R8 released output", rdata, 9'h1FF);
    oe_n = 0; #1;
    check(rdata == 0, "R8 driven output", rdata, 0);

    @(negedge wclk);
    wdata = 9'h055; wen1_n = 0; wen2_ld = 0;
    repeat (3) @(negedge wclk);
    wen1_n = 1; wen2_ld = 1;
    settle();
    check(empty_n == 0, "R3 second enable low blocks write", empty_n, 0);

    wr_burst(7, 9'h100);
    settle();
    check(empty_n == 1, "R6 empty released", empty_n, 1);
    check(aempty_n == 0, "R7 seven words almost empty", aempty_n, 0);
    wr_burst(1, 9'h107);
    settle();
    check(aempty_n == 1, "R7 eight words not almost empty", aempty_n, 1);
    check(afull_n == 1, "R7 eight free not almost full", afull_n, 1);
    wr_burst(1, 9'h108);
    settle();
    check(afull_n == 0, "R7 seven free almost full", afull_n, 0);
    wr_burst(7, 9'h109);
    settle();
    check(full_n == 0, "R6 full at depth", full_n, 0);

    @(negedge wclk);
    wdata = 9'h1AA; wen1_n = 0; wen2_ld = 1;
    repeat (2) @(negedge wclk);
    wen1_n = 1;
    settle();
    check(mq.size() == DEPTH, "R5 model unchanged by write on full", mq.size(), DEPTH);

    @(negedge rclk);
    ren1_n = 0; ren2_n = 1;
    repeat (3) @(negedge rclk);
    ren1_n = 1; ren2_n = 0;
    repeat (3) @(negedge rclk);
    ren2_n = 1;
    settle();
    check(full_n == 0, "R4 single enable reads nothing", full_n, 0);
    check(rdata == 0, "R4 output register held", rdata, 0);

    rd_burst(1);
    settle();
    check(full_n == 1, "R6 full released after read", full_n, 1);
    check(afull_n == 0, "R7 one free still almost full", afull_n, 0);
    rd_burst(15);
    settle();
    check(empty_n == 0 && aempty_n == 0, "R6 drained", {empty_n, aempty_n}, 0);
    check(rdata == 9'h10F, "R6 last word", rdata, 9'h10F);

    @(negedge rclk);
    ren1_n = 0; ren2_n = 0;
    repeat (3) @(negedge rclk);
    ren1_n = 1; ren2_n = 1;
    settle();
    check(rdata == 9'h10F, "R5 read on empty holds output", rdata, 9'h10F);

    fork
      wr_burst(40, 9'h040);
      rd_burst(40);
    join
    settle();
    check(mq.size() == 0 && empty_n == 0, "R6 streaming drained", mq.size(), 0);

    // programmable-flag mode
    do_reset(1'b0);
    @(negedge wclk);
    wen1_n = 0; wen2_ld = 0; wdata = 9'd5;
    @(negedge wclk); wdata = 9'd2;
    @(negedge wclk); wdata = 9'd3;
    @(negedge wclk); wen1_n = 1; wen2_ld = 1;
    settle();
    check(empty_n == 0, "R9 loads write no data", empty_n, 0);
    check(rdata == 0, "R2 mode reset keeps output clear", rdata, 0);

    wr_burst(3, 9'h0A0);
    settle();
    check(aempty_n == 0, "R9 three words at loaded threshold", aempty_n, 0);
    wr_burst(1, 9'h0A3);
    settle();
    check(aempty_n == 1, "R9 wrap put 3 in first threshold", aempty_n, 1);
    wr_burst(9, 9'h0A4);
    settle();
    check(afull_n == 1, "R9 three free not almost full", afull_n, 1);
    wr_burst(1, 9'h0AD);
    settle();
    check(afull_n == 0, "R9 two free almost full", afull_n, 0);
    check(mq.size() == 14, "R3 writes with load high in flag mode", mq.size(), 14);
    rd_burst(14);
    settle();
    check(empty_n == 0 && rdata == 9'h0AD, "R6 flag mode drained", rdata, 9'h0AD);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule